// File: doc/BRIEF.md
# Device register window decoder

This block places one physically addressed window of device registers in the memory map and decides, for every uncached load or store, whether the access belongs to that window or continues to ordinary memory. Software sets up the window through a single packed control register. That register holds an enable, the window's base address, the number of 64-byte register blocks the window spans, and a flag that keeps block 0 back from normal device use. The window is at most 32 KB.

On a hit, the block reports the index of the 64-byte register block and the byte offset within it. The device store beside this block returns the permission bits of the access-control word. That word sits in the first register word of the device that owns the block. The decoder checks these bits against the requester's privilege mode and the access direction. It raises a fault when a user or supervisor access is not granted. All request-side outputs are combinational from the request and the stored control register.

Top module: `devwin_top`

## Requirements
- R1: After a synchronous reset, `cfg_rdata` reads 0, so the window is disabled and no request hits.
- R2: The control register holds the base address in bits 31..11, which stand for physical address bits 35..15. Bit 10 is the enable, bit 9 is the block-0 reserved flag, and bits 8..0 hold the last valid block index. A write is visible on `cfg_rdata` from the next cycle. Base bits for physical address bits at or above `PA_W` read 0 and take no part in the compare.
- R3: While the enable bit is 0, `win_hit` and `dev_fault` stay 0 for every request.
- R4: With the window enabled and `req_valid` high, a request hits when physical address bits 35..15 (zero-extended) equal the base. On a hit, `blk_idx` is address bits 14..6 and `blk_off` is address bits 5..0. Without a hit, both read 0.
- R5: A request whose block index is greater than the last valid block index does not hit. A request whose index equals it does hit.
- R6: A request whose address bits 35..15 differ from the base does not hit.
- R7: `req_mode` encodes 00 as kernel, 01 as supervisor, and 10 or 11 as user. Kernel requests never fault.
- R8: The permission input carries four grant bits: bit 0 grants user read, bit 1 user write, bit 2 supervisor read, and bit 3 supervisor write. A user or supervisor hit faults when the grant bit for its mode and direction is 0.
- R9: When the reserved flag is 1, a user or supervisor hit on block 0 faults whatever the grant bits are, and a kernel hit does not. When the flag is 0, block 0 is checked like any other block.
- R10: `dev_fault` is 0 whenever `win_hit` is 0, including when `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| req_valid | input | 1 | Request present |
| req_paddr | input | PA_W | Request physical address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege mode of the request |
| acw_perm | input | 4 | Grant bits from the owning device's access-control word |
| win_hit | output | 1 | Request claimed by the window |
| blk_idx | output | 9 | Register block index within the window |
| blk_off | output | 6 | Byte offset within the block |
| dev_fault | output | 1 | Permission fault for a claimed request |

## Verification
The bench builds the block with `PA_W` = 32, the most common implemented width. With that width, control bits 31..28 must read 0 and be left out of the base compare, so that masking is exercised. With only 32 address bits, the window base is covered by bits 31..15, which lets a single instance reach the base match and mismatch, the last-block bound on both sides, every mode, direction and grant-bit combination, and the reserved block 0 with the flag set and clear.

// File: rtl/devwin_pkg.sv
package devwin_pkg;

    // Register block geometry and control register layout
    localparam int BLK_LG    = 6;                 // 64-byte blocks
    localparam int IDX_W     = 9;                 // up to 512 blocks
    localparam int WIN_LG    = BLK_LG + IDX_W;    // 32 KB window span
    localparam int CFG_W     = 32;
    localparam int MAX_PA_W  = 36;
    localparam int BASE_W    = MAX_PA_W - WIN_LG; // 21 base bits
    localparam int BASE_LSB  = 11;
    localparam int EN_BIT    = 10;
    localparam int RSV_BIT   = 9;
    localparam int PERM_W    = 4;

    // Grant bit positions
    localparam int G_UR = 0;
    localparam int G_UW = 1;
    localparam int G_SR = 2;
    localparam int G_SW = 3;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10,
        MODE_USER2  = 2'b11
    } priv_mode_e;

    typedef struct packed {
        logic             en;
        logic             rsv0;
        logic [IDX_W-1:0] last_blk;
    } win_ctl_t;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [BLK_LG-1:0] off;
    } win_dec_t;

    function automatic logic grant_ok(input priv_mode_e m, input logic wr,
                                      input logic [PERM_W-1:0] g);
        case (m)
            MODE_KERNEL: return 1'b1;
            MODE_SUPER:  return wr ? g[G_SW] : g[G_SR];
            default:     return wr ? g[G_UW] : g[G_UR];
        endcase
    endfunction

endpackage

// File: rtl/devwin_cfg.sv
module devwin_cfg
    import devwin_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [CFG_W-1:0]    wdata,
    output logic [CFG_W-1:0]    rdata,
    output win_ctl_t            ctl,
    output logic [BASE_W-1:0]   base
);
    localparam int IMPL_BASE_W = PA_W - WIN_LG;
    localparam logic [BASE_W-1:0] IMPL_MASK = BASE_W'((64'd1 << IMPL_BASE_W) - 64'd1);

    logic [BASE_W-1:0] base_q;
    win_ctl_t          ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctl_q  <= '0;
        end else if (we) begin
            base_q       <= wdata[BASE_LSB +: BASE_W];
            ctl_q.en     <= wdata[EN_BIT];
            ctl_q.rsv0   <= wdata[RSV_BIT];
            ctl_q.last_blk <= wdata[IDX_W-1:0];
        end
    end

    // Unimplemented upper address bits read and compare as zero
    assign base = base_q & IMPL_MASK;
    assign ctl  = ctl_q;

    always_comb begin
        rdata                     = '0;
        rdata[BASE_LSB +: BASE_W] = base;
        rdata[EN_BIT]             = ctl_q.en;
        rdata[RSV_BIT]            = ctl_q.rsv0;
        rdata[IDX_W-1:0]          = ctl_q.last_blk;
    end
endmodule

// File: rtl/devwin_match.sv
module devwin_match
    import devwin_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic              valid,
    input  logic [PA_W-1:0]   paddr,
    input  logic [BASE_W-1:0] base,
    input  win_ctl_t          ctl,
    output win_dec_t          dec
);
    logic [MAX_PA_W-1:0] pa_full;
    logic [IDX_W-1:0]    idx;
    logic                in_base;
    logic                in_size;
    logic                hit;

    always_comb begin
        pa_full = MAX_PA_W'(paddr);
        idx     = pa_full[WIN_LG-1:BLK_LG];
        in_base = (pa_full[MAX_PA_W-1:WIN_LG] == base);
        in_size = (idx <= ctl.last_blk);
        hit     = valid & ctl.en & in_base & in_size;
        dec.hit = hit;
        dec.idx = hit ? idx : '0;
        dec.off = hit ? pa_full[BLK_LG-1:0] : '0;
    end
endmodule

// File: rtl/devwin_perm.sv
module devwin_perm
    import devwin_pkg::*;
(
    input  win_dec_t          dec,
    input  logic              rsv0,
    input  logic [1:0]        mode,
    input  logic              wr,
    input  logic [PERM_W-1:0] grant,
    output logic              fault
);
    priv_mode_e m;
    logic       reserved_blk;

    always_comb begin
        m            = priv_mode_e'(mode);
        reserved_blk = rsv0 && (dec.idx == '0);
        fault        = dec.hit && (m != MODE_KERNEL) &&
                       (reserved_blk || !grant_ok(m, wr, grant));
    end
endmodule

// File: rtl/devwin_top.sv
module devwin_top
    import devwin_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [PA_W-1:0]   req_paddr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [3:0]        acw_perm,
    output logic              win_hit,
    output logic [8:0]        blk_idx,
    output logic [5:0]        blk_off,
    output logic              dev_fault
);
    win_ctl_t          ctl;
    logic [BASE_W-1:0] base;
    win_dec_t          dec;

    devwin_cfg #(.PA_W(PA_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ctl   (ctl),
        .base  (base)
    );

    devwin_match #(.PA_W(PA_W)) u_match (
        .valid (req_valid),
        .paddr (req_paddr),
        .base  (base),
        .ctl   (ctl),
        .dec   (dec)
    );

    devwin_perm u_perm (
        .dec   (dec),
        .rsv0  (ctl.rsv0),
        .mode  (req_mode),
        .wr    (req_write),
        .grant (acw_perm),
        .fault (dev_fault)
    );

    assign win_hit = dec.hit;
    assign blk_idx = dec.idx;
    assign blk_off = dec.off;
endmodule

// File: rtl/devwin_checker.sv
module devwin_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic       req_valid,
    input logic [1:0] req_mode,
    input logic       win_hit,
    input logic [8:0] blk_idx,
    input logic       dev_fault
);
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[10:0] == $past(cfg_wdata[10:0])); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata)); // R2
    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[10] |-> !win_hit && !dev_fault); // R3
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> blk_idx <= cfg_rdata[8:0]); // R5
    AST_KERNEL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        req_mode == 2'b00 |-> !dev_fault); // R7
    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        dev_fault |-> win_hit); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !win_hit && !dev_fault); // R10
endmodule

bind devwin_top devwin_checker u_devwin_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .win_hit   (win_hit),
    .blk_idx   (blk_idx),
    .dev_fault (dev_fault)
);

// File: tb/devwin_top_bench.sv
module devwin_top_bench;
    localparam int PA_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [PA_W-1:0] req_paddr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [3:0]  acw_perm = '0;
    logic        win_hit;
    logic [8:0]  blk_idx;
    logic [5:0]  blk_off;
    logic        dev_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    devwin_top #(.PA_W(PA_W)) u_devwin_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_paddr(req_paddr),
        .req_write(req_write), .req_mode(req_mode), .acw_perm(acw_perm),
        .win_hit(win_hit), .blk_idx(blk_idx), .blk_off(blk_off),
        .dev_fault(dev_fault)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input logic [16:0] base, input logic en,
                                          input logic rsv, input logic [8:0] last);
        return {4'b0, base, en, rsv, last};
    endfunction

    function automatic logic [31:0] mkaddr(input logic [16:0] base, input logic [8:0] idx,
                                           input logic [5:0] off);
        return {base, idx, off};
    endfunction

    task automatic wr_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic v, input logic [31:0] a, input logic w,
                         input logic [1:0] m, input logic [3:0] g);
        @(negedge clk);
        req_valid = v;
        req_paddr = a;
        req_write = w;
        req_mode = m;
        acw_perm = g;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 cfg after reset", cfg_rdata, 32'h0);
        probe(1'b1, 32'h0, 1'b0, 2'b00, 4'hF);
        chk("R1 no hit after reset", {31'b0, win_hit}, 32'h0);
    endtask

    task automatic t_cfg_rw();
        wr_cfg(32'hFFFF_FFFF);
        chk("R2 upper bits masked", cfg_rdata, 32'h0FFF_FFFF);
        wr_cfg(mkcfg(17'h0_1234, 1'b1, 1'b0, 9'd20));
        chk("R2 packed readback", cfg_rdata, mkcfg(17'h0_1234, 1'b1, 1'b0, 9'd20));
    endtask

    task automatic t_disabled();
        wr_cfg(mkcfg(17'h0_1234, 1'b0, 1'b0, 9'd20));
        probe(1'b1, mkaddr(17'h0_1234, 9'd3, 6'd0), 1'b0, 2'b10, 4'h0);
        chk("R3 disabled no hit", {31'b0, win_hit}, 32'h0);
        chk("R3 disabled no fault", {31'b0, dev_fault}, 32'h0);
    endtask

    task automatic t_decode();
        wr_cfg(mkcfg(17'h0_1234, 1'b1, 1'b0, 9'd20));
        probe(1'b1, mkaddr(17'h0_1234, 9'd5, 6'h2C), 1'b0, 2'b00, 4'h0);
        chk("R4 hit", {31'b0, win_hit}, 32'h1);
        chk("R4 index", {23'b0, blk_idx}, 32'd5);
        chk("R4 offset", {26'b0, blk_off}, 32'h2C);
        chk("R7 kernel no fault", {31'b0, dev_fault}, 32'h0);
        probe(1'b1, mkaddr(17'h0_1234, 9'd0, 6'h3F), 1'b1, 2'b00, 4'h0);
        chk("R4 block 0 last byte", {22'b0, win_hit, blk_idx, blk_off}, {22'b0, 1'b1, 9'd0, 6'h3F});
    endtask

    task automatic t_limit();
        probe(1'b1, mkaddr(17'h0_1234, 9'd20, 6'h01), 1'b0, 2'b00, 4'h0);
        chk("R5 last block hits", {22'b0, win_hit, blk_idx, blk_off}, {22'b0, 1'b1, 9'd20, 6'h01});
        probe(1'b1, mkaddr(17'h0_1234, 9'd21, 6'h01), 1'b0, 2'b00, 4'h0);
        chk("R5 past last misses", {31'b0, win_hit}, 32'h0);
        chk("R4 miss outputs zero", {17'b0, blk_idx, blk_off}, 32'h0);
    endtask

    task automatic t_mismatch();
        probe(1'b1, mkaddr(17'h0_1235, 9'd2, 6'h0), 1'b0, 2'b00, 4'h0);
        chk("R6 base+1 misses", {31'b0, win_hit}, 32'h0);
        probe(1'b1, mkaddr(17'h1_1234, 9'd2, 6'h0), 1'b0, 2'b00, 4'h0);
        chk("R6 top bit differs", {31'b0, win_hit}, 32'h0);
    endtask

    task automatic t_perm();
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int g = 0; g < 16; g++) begin
                    logic exp_f;
                    logic [3:0] gb;
                    gb = 4'(g);
                    if (m == 0)      exp_f = 1'b0;
                    else if (m == 1) exp_f = (w != 0) ? !gb[3] : !gb[2];
                    else             exp_f = (w != 0) ? !gb[1] : !gb[0];
                    probe(1'b1, mkaddr(17'h0_1234, 9'd7, 6'h4), w[0], 2'(m), gb);
                    chk((m == 0) ? "R7 kernel grants" : "R8 grant check",
                        {30'b0, win_hit, dev_fault}, {30'b0, 1'b1, exp_f});
                end
            end
        end
    endtask

    task automatic t_reserved();
        wr_cfg(mkcfg(17'h0_1234, 1'b1, 1'b1, 9'd20));
        probe(1'b1, mkaddr(17'h0_1234, 9'd0, 6'h8), 1'b0, 2'b10, 4'hF);
        chk("R9 reserved user faults", {30'b0, win_hit, dev_fault}, 32'h3);
        probe(1'b1, mkaddr(17'h0_1234, 9'd0, 6'h8), 1'b1, 2'b01, 4'hF);
        chk("R9 reserved super faults", {30'b0, win_hit, dev_fault}, 32'h3);
        probe(1'b1, mkaddr(17'h0_1234, 9'd0, 6'h8), 1'b1, 2'b00, 4'h0);
        chk("R9 reserved kernel ok", {30'b0, win_hit, dev_fault}, 32'h2);
        probe(1'b1, mkaddr(17'h0_1234, 9'd1, 6'h8), 1'b0, 2'b10, 4'hF);
        chk("R9 block 1 normal", {30'b0, win_hit, dev_fault}, 32'h2);
        wr_cfg(mkcfg(17'h0_1234, 1'b1, 1'b0, 9'd20));
        probe(1'b1, mkaddr(17'h0_1234, 9'd0, 6'h8), 1'b0, 2'b10, 4'hF);
        chk("R9 flag clear block 0 normal", {30'b0, win_hit, dev_fault}, 32'h2);
    endtask

    task automatic t_gate();
        probe(1'b0, mkaddr(17'h0_1234, 9'd3, 6'h0), 1'b1, 2'b10, 4'h0);
        chk("R10 idle no hit no fault", {30'b0, win_hit, dev_fault}, 32'h0);
        probe(1'b1, mkaddr(17'h0_0001, 9'd3, 6'h0), 1'b1, 2'b10, 4'h0);
        chk("R10 outside no fault", {30'b0, win_hit, dev_fault}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_cfg_rw();
        t_disabled();
        t_decode();
        t_limit();
        t_mismatch();
        t_perm();
        t_reserved();
        t_gate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule